// File: doc/BRIEF.md
# ADC Self-Calibration Sequencer

This block holds the digital control for an analog-to-digital converter's self-calibration routine. Software reaches it through a small register file. One configuration write both checks the trigger mode and launches the run. The sequencer then takes eight averaged measurements in a fixed order. For each measurement it sends 32 conversion requests to the converter core over a one-cycle request / one-cycle result-valid handshake, and adds up the 16-bit results. It writes each average straight into its destination register: the first one goes to the offset-correction register, and the other seven go to a bank of plus-side calibration registers.

The run is refused when hardware triggering is selected. Any register write or a stop-mode request during the run aborts it. Whether the run ends normally or by abort, the block raises the ordinary conversion-complete flag and, if enabled, the interrupt. The controller states are `ST_IDLE` (waiting), `ST_ISSUE` (one request pulse), `ST_WAIT` (waiting for a result and accumulating it), `ST_STORE` (writing an average and advancing the point) and `ST_FINISH` (normal end). The transitions are:

- start: `ST_IDLE` to `ST_ISSUE`.
- request: `ST_ISSUE` to `ST_WAIT`.
- next sample: `ST_WAIT` to `ST_ISSUE`.
- burst full: `ST_WAIT` to `ST_STORE`.
- next point: `ST_STORE` to `ST_ISSUE`.
- last point: `ST_STORE` to `ST_FINISH`.
- complete: `ST_FINISH` to `ST_IDLE`.
- abort: from any active state to `ST_IDLE`.

Register map (16-bit registers):

- Address 0, control: bits [4:0] channel select, bit 5 continuous mode, bit 6 interrupt enable, bit 7 conversion-complete flag (read-only).
- Address 1, configuration: bit 0 hardware-trigger select, bit 1 calibration start (reads 1 while the run is active), bit 2 fail flag (write 1 to clear), bits [4:3] resolution, bit 5 compare enable, bit 6 single-ended select.
- Address 2: offset correction.
- Addresses 3 to 7: plus-side points P0 to P4.
- Address 8: plus-side point PS.
- Address 9: plus-side point PD.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, every register reads 0 and `conv_req` and `irq` are low.
- R2: A configuration write with bit 1 = 1 and bit 0 = 0, made while idle, starts the run. Bit 1 then reads 1, and the first request carries point code 0.
- R3: A configuration write with bits 1 and 0 both set leaves bit 1 reading 0 and sets the fail flag. No request is issued and the complete flag stays 0.
- R4: Requests are single-cycle pulses, with at most one outstanding. Exactly 32 requests go out per point. Point codes run 0 (offset), 1 (PD), 2 (PS), 3 (P4), 4 (P3), 5 (P2), 6 (P1), 7 (P0): 256 requests in all.
- R5: Each point stores (sum of its 32 results) >> 5 into its register, without overflow for full-scale inputs.
- R6: On normal completion, bit 1 returns to 0, the complete flag is set and the fail flag is unchanged.
- R7: `irq` is high exactly when the complete flag and the interrupt enable are both 1.
- R8: Any register write during the run aborts it. Bit 1 reads 0, the fail flag and the complete flag are set, the written register keeps its old value, and no further requests go out.
- R9: A `stop_req` pulse during the run aborts it with the same flag effects as R8.
- R10: Writing 1 to configuration bit 2 while idle clears the fail flag. A new start written with bit 2 = 0 leaves it set.
- R11: The channel, continuous, resolution, compare and single-ended fields have no effect on the point sequence or the stored results.
- R12: A write to the control register while idle clears the complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| stop_req | input | 1 | Stop-mode entry request |
| conv_req | output | 1 | One-cycle conversion request to the converter core |
| conv_point | output | 3 | Calibration point code for the current request |
| conv_valid | input | 1 | One-cycle result strobe from the core |
| conv_data | input | 16 | Conversion result |
| irq | output | 1 | Calibration-end interrupt |

## Verification
A point counter that skips or repeats a value shows on `conv_point` at the next request, and on the wrong register at the end. A wrong burst count shifts every later point's average by one sample. Both are caught once the whole run has been read back. A state machine stuck active shows as start bit 1 still reading 1 long after the 256th result, and the end-of-run wait then times out. An abort that fails to return to idle shows up within a few cycles as a fresh request after the offending write or stop pulse.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL     = 4'd0;
    localparam logic [REG_AW-1:0] A_CFG      = 4'd1;
    localparam logic [REG_AW-1:0] A_OFFSET   = 4'd2;
    localparam logic [REG_AW-1:0] A_PLUSBASE = 4'd3;

    // control register bits
    localparam int B_CHAN_LSB = 0;
    localparam int B_CONT     = 5;
    localparam int B_IEN      = 6;
    localparam int B_DONE     = 7;

    // configuration register bits
    localparam int B_TRIG     = 0;
    localparam int B_START    = 1;
    localparam int B_FAIL     = 2;
    localparam int B_RES_LSB  = 3;
    localparam int B_CMP      = 5;
    localparam int B_SE       = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_STORE,
        ST_FINISH
    } cal_state_e;

endpackage

// File: rtl/adc_cal_accum.sv
module adc_cal_accum #(
    parameter int DATA_W   = 16,
    parameter int AVG_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] avg,
    output logic              burst_last
);
    localparam int SUM_W = DATA_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2;

    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + {{AVG_LOG2{1'b0}}, sample};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the sample being added now is the final one of the burst
    assign burst_last = (cnt_q == {CNT_W{1'b1}});
    assign avg        = sum_q[SUM_W-1:AVG_LOG2];

endmodule

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
    import adc_cal_pkg::*;
#(
    parameter int NUM_POINTS = 8,
    parameter int PT_W       = $clog2(NUM_POINTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_go,
    input  logic            abort_evt,
    input  logic            conv_valid,
    input  logic            burst_last,
    output logic            conv_req,
    output logic [PT_W-1:0] point,
    output logic            acc_clr,
    output logic            acc_add,
    output logic            store_en,
    output logic            busy,
    output logic            end_ok,
    output logic            end_abort
);
    localparam logic [PT_W-1:0] PT_LAST = PT_W'(NUM_POINTS - 1);

    cal_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            point <= '0;
        else if (state_q == ST_IDLE)
            point <= '0;
        else if (store_en && point != PT_LAST)
            point <= point + 1'b1;
    end

    always_comb begin
        state_d   = state_q;
        conv_req  = 1'b0;
        acc_clr   = 1'b0;
        acc_add   = 1'b0;
        store_en  = 1'b0;
        end_ok    = 1'b0;
        end_abort = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_clr = 1'b1;
                if (start_go) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (abort_evt) begin
                    end_abort = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    conv_req = 1'b1;
                    state_d  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (abort_evt) begin
                    end_abort = 1'b1;
                    state_d   = ST_IDLE;
                end else if (conv_valid) begin
                    acc_add = 1'b1;
                    state_d = burst_last ? ST_STORE : ST_ISSUE;
                end
            end
            ST_STORE: begin
                if (abort_evt) begin
                    end_abort = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    store_en = 1'b1;
                    acc_clr  = 1'b1;
                    state_d  = (point == PT_LAST) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_FINISH: begin
                if (abort_evt) begin
                    end_abort = 1'b1;
                end else begin
                    end_ok = 1'b1;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
    import adc_cal_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_POINTS = 8,
    parameter int PT_W       = $clog2(NUM_POINTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stop_req,
    input  logic              busy,
    input  logic              store_en,
    input  logic [PT_W-1:0]   point,
    input  logic [DATA_W-1:0] avg,
    input  logic              end_ok,
    input  logic              end_abort,
    output logic              start_go,
    output logic              abort_evt,
    output logic              fail_flag,
    output logic              done_flag,
    output logic              irq
);
    localparam int NUM_PLUS = NUM_POINTS - 1;

    logic [4:0]        chan_q;
    logic              cont_q;
    logic              ien_q;
    logic              trig_q;
    logic [1:0]        res_q;
    logic              cmp_q;
    logic              se_q;
    logic [DATA_W-1:0] offset_q;
    logic [DATA_W-1:0] plus_q [NUM_PLUS];

    logic cfg_wr, wr_ok, refuse;

    assign cfg_wr    = wr_en && (wr_addr == A_CFG);
    assign wr_ok     = wr_en && !busy;
    assign start_go  = !busy && cfg_wr && wr_data[B_START] && !wr_data[B_TRIG];
    assign refuse    = !busy && cfg_wr && wr_data[B_START] &&  wr_data[B_TRIG];
    assign abort_evt = busy && (wr_en || stop_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q    <= '0;
            cont_q    <= 1'b0;
            ien_q     <= 1'b0;
            done_flag <= 1'b0;
            trig_q    <= 1'b0;
            res_q     <= '0;
            cmp_q     <= 1'b0;
            se_q      <= 1'b0;
            fail_flag <= 1'b0;
            offset_q  <= '0;
            for (int i = 0; i < NUM_PLUS; i++) plus_q[i] <= '0;
        end else begin
            if (wr_ok) begin
                if (wr_addr == A_CTRL) begin
                    chan_q    <= wr_data[B_CHAN_LSB +: 5];
                    cont_q    <= wr_data[B_CONT];
                    ien_q     <= wr_data[B_IEN];
                    done_flag <= 1'b0;
                end
                if (wr_addr == A_CFG) begin
                    trig_q <= wr_data[B_TRIG];
                    res_q  <= wr_data[B_RES_LSB +: 2];
                    cmp_q  <= wr_data[B_CMP];
                    se_q   <= wr_data[B_SE];
                    if (wr_data[B_FAIL]) fail_flag <= 1'b0;
                end
                if (wr_addr == A_OFFSET) offset_q <= wr_data;
                for (int i = 0; i < NUM_PLUS; i++) begin
                    if (wr_addr == REG_AW'(int'(A_PLUSBASE) + i)) plus_q[i] <= wr_data;
                end
            end
            if (refuse) fail_flag <= 1'b1;
            // point 0 is the offset; codes 1..NUM_PLUS fill the bank from the top down
            if (store_en) begin
                if (point == '0) offset_q <= avg;
                for (int i = 0; i < NUM_PLUS; i++) begin
                    if (point == PT_W'(NUM_PLUS - i)) plus_q[i] <= avg;
                end
            end
            if (end_ok || end_abort) done_flag <= 1'b1;
            if (end_abort)           fail_flag <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)
            rd_data = {{(DATA_W-8){1'b0}}, done_flag, ien_q, cont_q, chan_q};
        else if (rd_addr == A_CFG)
            rd_data = {{(DATA_W-7){1'b0}}, se_q, cmp_q, res_q, fail_flag, busy, trig_q};
        else if (rd_addr == A_OFFSET)
            rd_data = offset_q;
        else begin
            for (int i = 0; i < NUM_PLUS; i++) begin
                if (rd_addr == REG_AW'(int'(A_PLUSBASE) + i)) rd_data = plus_q[i];
            end
        end
    end

    assign irq = done_flag && ien_q;

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int AVG_LOG2   = 5,
    parameter int NUM_POINTS = 8,
    parameter int PT_W       = $clog2(NUM_POINTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stop_req,
    output logic              conv_req,
    output logic [PT_W-1:0]   conv_point,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq
);
    logic              start_go, abort_evt, cal_busy;
    logic              acc_clr, acc_add, burst_last, store_en;
    logic              end_ok, end_abort, fail_flag, done_flag;
    logic [DATA_W-1:0] avg;

    adc_cal_fsm #(
        .NUM_POINTS (NUM_POINTS),
        .PT_W       (PT_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .abort_evt  (abort_evt),
        .conv_valid (conv_valid),
        .burst_last (burst_last),
        .conv_req   (conv_req),
        .point      (conv_point),
        .acc_clr    (acc_clr),
        .acc_add    (acc_add),
        .store_en   (store_en),
        .busy       (cal_busy),
        .end_ok     (end_ok),
        .end_abort  (end_abort)
    );

    adc_cal_accum #(
        .DATA_W   (DATA_W),
        .AVG_LOG2 (AVG_LOG2)
    ) i_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (acc_clr),
        .add_en     (acc_add),
        .sample     (conv_data),
        .avg        (avg),
        .burst_last (burst_last)
    );

    adc_cal_regs #(
        .DATA_W     (DATA_W),
        .NUM_POINTS (NUM_POINTS),
        .PT_W       (PT_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .stop_req  (stop_req),
        .busy      (cal_busy),
        .store_en  (store_en),
        .point     (conv_point),
        .avg       (avg),
        .end_ok    (end_ok),
        .end_abort (end_abort),
        .start_go  (start_go),
        .abort_evt (abort_evt),
        .fail_flag (fail_flag),
        .done_flag (done_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
    parameter int DATA_W = 16,
    parameter int PT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              stop_req,
    input logic              conv_req,
    input logic [PT_W-1:0]   conv_point,
    input logic              cal_busy,
    input logic              fail_flag,
    input logic              done_flag,
    input logic              irq
);
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    p_point_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && $past(cal_busy) && !$stable(conv_point))
            |-> (conv_point == $past(conv_point) + 1'b1));

    p_req_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> cal_busy);

    p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy && wr_en && wr_addr == 4'd1 && wr_data[1] && wr_data[0])
            |=> (!cal_busy && fail_flag));

    p_abort_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && wr_en) |=> (!cal_busy && fail_flag && done_flag));

    p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && stop_req) |=> (!cal_busy && fail_flag && done_flag));

    p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> done_flag);

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

endmodule

bind adc_cal_seq adc_cal_seq_chk #(
    .DATA_W (DATA_W),
    .PT_W   (PT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stop_req   (stop_req),
    .conv_req   (conv_req),
    .conv_point (conv_point),
    .cal_busy   (cal_busy),
    .fail_flag  (fail_flag),
    .done_flag  (done_flag),
    .irq        (irq)
);

// File: tb/test_adc_cal_seq.sv
`timescale 1ns/1ps
module test_adc_cal_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        stop_req = 1'b0;
    logic        conv_req;
    logic [2:0]  conv_point;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;

    // converter model controls: 0 ramp data, 1 full scale, 2 never answers
    int mode = 0;
    int epoch = 0;
    int seen_epoch = 0;
    int req_cnt = 0;
    int rsp_cnt = 0;
    int order_err = 0;
    bit pend = 1'b0;

    always #4 clk = ~clk;

    adc_cal_seq i_adc_cal_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .stop_req(stop_req), .conv_req(conv_req),
        .conv_point(conv_point), .conv_valid(conv_valid), .conv_data(conv_data), .irq(irq)
    );

    always @(negedge clk) begin
        if (seen_epoch != epoch) begin
            seen_epoch = epoch;
            req_cnt = 0; rsp_cnt = 0; order_err = 0; pend = 1'b0;
        end
        conv_valid = 1'b0;
        if (pend && mode != 2) begin
            conv_valid = 1'b1;
            conv_data  = (mode == 1) ? 16'hFFFF
                       : 16'(int'(conv_point) * 4096 + (rsp_cnt % 32) * 5);
            rsp_cnt++;
            pend = 1'b0;
        end
        if (conv_req) begin
            if (pend) order_err++;
            if (req_cnt >= 256 || int'(conv_point) != req_cnt / 32) order_err++;
            req_cnt++;
            pend = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_end(output bit ok);
        logic [15:0] v;
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(4'd0, v);
            if (v[7]) begin ok = 1'b1; break; end
        end
    endtask

    function automatic logic [3:0] dest_addr(input int pt);
        return (pt == 0) ? 4'd2 : 4'(3 + (7 - pt));
    endfunction

    task automatic check_results(input string req, input bit full);
        logic [15:0] v;
        for (int p = 0; p < 8; p++) begin
            rd(dest_addr(p), v);
            chk(req, v, full ? 16'hFFFF : 16'(p * 4096 + 77));
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 conv_req low", conv_req, 0);
        chk("R1 irq low", irq, 0);
    endtask

    task automatic t_full_cal;
        logic [15:0] v;
        bit ok;
        mode = 0; epoch++;
        wr(4'd0, 16'h0040);
        wr(4'd1, 16'h0002);
        rd(4'd1, v);
        chk("R2 start bit reads 1", v[1], 1);
        wait_end(ok);
        chk("R6 run ended", ok, 1);
        chk("R4 request count", req_cnt, 256);
        chk("R4 point order", order_err, 0);
        check_results("R5 averaged ramp", 1'b0);
        rd(4'd1, v);
        chk("R6 start clear", v[1], 0);
        chk("R6 fail clear", v[2], 0);
        chk("R7 irq on end", irq, 1);
        wr(4'd0, 16'h0000);
        rd(4'd0, v);
        chk("R12 done cleared", v[7], 0);
        chk("R7 irq low after clear", irq, 0);
        wr(4'd0, 16'h0040);
        chk("R7 irq low with enable only", irq, 0);
    endtask

    task automatic t_saturate;
        bit ok;
        mode = 1; epoch++;
        wr(4'd1, 16'h0002);
        wait_end(ok);
        chk("R5 run ended", ok, 1);
        check_results("R5 full scale", 1'b1);
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_ignored;
        bit ok;
        mode = 0; epoch++;
        wr(4'd0, 16'h003F);
        wr(4'd1, 16'h007A);
        wait_end(ok);
        chk("R11 run ended", ok, 1);
        chk("R11 point order", order_err, 0);
        chk("R11 request count", req_cnt, 256);
        check_results("R11 results unchanged", 1'b0);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0000);
    endtask

    task automatic t_refuse;
        logic [15:0] v;
        bit ok;
        mode = 0; epoch++;
        wr(4'd1, 16'h0003);
        repeat (10) @(negedge clk);
        rd(4'd1, v);
        chk("R3 start refused", v[1], 0);
        chk("R3 fail set", v[2], 1);
        rd(4'd0, v);
        chk("R3 no done", v[7], 0);
        chk("R3 no request", req_cnt, 0);
        wr(4'd1, 16'h0002);
        rd(4'd1, v);
        chk("R10 start runs", v[1], 1);
        chk("R10 fail kept on start", v[2], 1);
        wait_end(ok);
        rd(4'd1, v);
        chk("R10 fail kept after run", v[2], 1);
        wr(4'd1, 16'h0004);
        rd(4'd1, v);
        chk("R10 fail cleared by 1", v[2], 0);
        wr(4'd0, 16'h0040);
    endtask

    task automatic t_abort_write;
        logic [15:0] v, old;
        int n;
        mode = 2; epoch++;
        rd(4'd2, old);
        wr(4'd1, 16'h0002);
        repeat (5) @(negedge clk);
        wr(4'd2, 16'h1234);
        rd(4'd1, v);
        chk("R8 start cleared", v[1], 0);
        chk("R8 fail set", v[2], 1);
        rd(4'd0, v);
        chk("R8 done set", v[7], 1);
        chk("R8 irq on abort", irq, 1);
        rd(4'd2, v);
        chk("R8 write ignored", v, old);
        n = req_cnt;
        repeat (20) @(negedge clk);
        chk("R8 no more requests", req_cnt, n);
        wr(4'd1, 16'h0004);
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_abort_stop;
        logic [15:0] v;
        int n;
        mode = 2; epoch++;
        wr(4'd1, 16'h0002);
        repeat (4) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        rd(4'd1, v);
        chk("R9 start cleared", v[1], 0);
        chk("R9 fail set", v[2], 1);
        rd(4'd0, v);
        chk("R9 done set", v[7], 1);
        n = req_cnt;
        repeat (20) @(negedge clk);
        chk("R9 no more requests", req_cnt, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_cal();
        t_saturate();
        t_ignored();
        t_refuse();
        t_abort_write();
        t_abort_stop();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule